// File: doc/BRIEF.md
# RTC Interrupt Flag and Request Logic

This block holds the interrupt state of a real-time clock. Three one-cycle event pulses arrive from elsewhere in the clock: a periodic tick, an alarm match and an update-ended strobe. Each pulse latches a pending flag. The flag is latched whether or not its source is enabled. A host reaches the block through a byte-wide register port with three registers. The control register holds one enable per source. The status register shows the pending flags and a summary bit, and reading it clears them. A third register reports whether RAM and time are valid.

The summary bit is 1 when at least one pending flag has its enable set. An active-low request output follows the summary bit. Register reads are combinational on the address. The side effects of a read, the clearing of flags, take effect at the clock edge that ends the read cycle.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset all enables and all flags are 0, the status register reads 0x00 and `irq_n_o` is 1.
- R2: A write to the control register (address 0x0B) loads the periodic enable from bit 6, the alarm enable from bit 5 and the update-ended enable from bit 4. Reading it back returns those three bits, and all its other bits read 0.
- R3: An event pulse sets its flag at the next clock edge, whatever its enable. `evt_i` bit 2 is periodic (status bit 6), bit 1 is alarm (status bit 5) and bit 0 is update-ended (status bit 4).
- R4: Status register (address 0x0C) bit 7 reads 1 exactly when some flag is set together with its enable.
- R5: `irq_n_o` is 0 in every cycle where status bit 7 would read 1, and 1 otherwise.
- R6: A read of the status register returns the flags as they stood before the read, and clears all of them at the edge that ends the read cycle.
- R7: An event pulse in the same cycle as a status read does not appear in that read, and its flag is still set for the next read.
- R8: Writes to the status register have no effect on any flag.
- R9: Bits 3 to 0 of the status register always read 0.
- R10: The validity register (address 0x0D) reads `vrt_i` in bit 7 and 0 in bits 6 to 0, and writes to it have no effect.
- R11: Reads of any address other than the status register leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 3 | Event pulses: bit 2 periodic, bit 1 alarm, bit 0 update-ended |
| vrt_i | input | 1 | RAM and time valid status |
| addr_i | input | 7 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on the address |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
A flag stuck at 0 shows up the next time the status register is read after its pulse. A flag stuck at 1 shows up on the read after a clearing read. A wrong enable shows up in the same cycle in both status bit 7 and `irq_n_o`, so the bench sweeps every enable pattern against every flag pattern and compares the two on every step. A clear that comes one cycle late, or that swallows an event arriving with the read, is caught by the status read that follows directly after.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   // Which register an address selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTL  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_VAL  = 2'd3
   } reg_sel_e;

   // Source index inside the event vector
   localparam int unsigned SRC_UPD = 0;
   localparam int unsigned SRC_ALM = 1;
   localparam int unsigned SRC_PER = 2;
endpackage

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
   parameter int unsigned N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic             clr_i,
   output logic [N_SRC-1:0] flag_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      // a new event wins over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_o[i] <= 1'b0;
         else if (evt_i[i]) flag_o[i] <= 1'b1;
         else if (clr_i)    flag_o[i] <= 1'b0;
      end

      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[i] |=> flag_o[i]) else $error("event lost");        // R3
      AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !evt_i[i]) |=> !flag_o[i]) else $error("not cleared"); // R6
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i && !evt_i[i]) |=> $stable(flag_o[i])) else $error("flag moved"); // R11
   end
endmodule

// File: rtl/rtc_irq_enables.sv
module rtc_irq_enables #(
   parameter int unsigned N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [N_SRC-1:0] wfield_i,
   output logic [N_SRC-1:0] en_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_o <= '0;
      else if (we_i) en_o <= wfield_i;
   end

   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (en_o == $past(wfield_i))) else $error("enable not loaded"); // R2
endmodule

// File: rtl/rtc_irq_rdmux.sv
module rtc_irq_rdmux
   import rtc_irq_pkg::*;
#(
   parameter int unsigned N_SRC   = 3,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SRC_LSB = 4
) (
   input  reg_sel_e         sel_i,
   input  logic [N_SRC-1:0] en_i,
   input  logic [N_SRC-1:0] flag_i,
   input  logic             summary_i,
   input  logic             vrt_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned TOP = DATA_W - 1;

   always_comb begin
      rdata_o = '0;
      unique case (sel_i)
         SEL_CTL:  rdata_o[SRC_LSB +: N_SRC] = en_i;
         SEL_STAT: begin
            rdata_o[TOP]                = summary_i;
            rdata_o[SRC_LSB +: N_SRC]   = flag_i;
         end
         SEL_VAL:  rdata_o[TOP] = vrt_i;
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int unsigned N_SRC    = 3,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned SRC_LSB  = 4,
   parameter int unsigned ADDR_CTL = 'h0B,
   parameter int unsigned ADDR_ST  = 'h0C,
   parameter int unsigned ADDR_VAL = 'h0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic              vrt_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_n_o
);
   localparam int unsigned FIELD_TOP = SRC_LSB + N_SRC;
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);
   localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(ADDR_ST);
   localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(ADDR_VAL);

   // elaboration checks on the configuration
   if (FIELD_TOP > DATA_W - 1) begin : g_bad_field
      $error("source field overlaps the summary bit");
   end
   if (ADDR_CTL == ADDR_ST || ADDR_ST == ADDR_VAL || ADDR_CTL == ADDR_VAL) begin : g_bad_map
      $error("register addresses collide");
   end
   if (N_SRC < 1) begin : g_bad_src
      $error("at least one source is needed");
   end

   reg_sel_e         sel;
   logic [N_SRC-1:0] en;
   logic [N_SRC-1:0] flag;
   logic             summary;
   logic             ctl_we;
   logic             st_clr;

   always_comb begin
      if      (addr_i == A_CTL) sel = SEL_CTL;
      else if (addr_i == A_ST)  sel = SEL_STAT;
      else if (addr_i == A_VAL) sel = SEL_VAL;
      else                      sel = SEL_NONE;
   end

   assign ctl_we  = wr_i && (sel == SEL_CTL);
   assign st_clr  = rd_i && (sel == SEL_STAT);
   assign summary = |(flag & en);
   assign irq_n_o = ~summary;

   rtc_irq_enables #(.N_SRC(N_SRC)) u_en (
      .clk(clk), .rst_n(rst_n), .we_i(ctl_we),
      .wfield_i(wdata_i[SRC_LSB +: N_SRC]), .en_o(en)
   );

   rtc_irq_flags #(.N_SRC(N_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(st_clr), .flag_o(flag)
   );

   rtc_irq_rdmux #(.N_SRC(N_SRC), .DATA_W(DATA_W), .SRC_LSB(SRC_LSB)) u_mux (
      .sel_i(sel), .en_i(en), .flag_i(flag), .summary_i(summary),
      .vrt_i(vrt_i), .rdata_o(rdata_o)
   );

   AST_ST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == A_ST) |-> (rdata_o[SRC_LSB-1:0] == '0)) else $error("low bits set"); // R9
   AST_VAL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == A_VAL) |-> (rdata_o == {vrt_i, {(DATA_W-1){1'b0}}})) else $error("bad validity read"); // R10
   AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == A_ST) |-> (irq_n_o == !rdata_o[DATA_W-1])) else $error("request mismatch"); // R5
   AST_ST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_ST && !rd_i && evt_i == '0) |=> $stable(flag)) else $error("write touched flags"); // R8
endmodule

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] evt = '0;
   logic       vrt = 1'b0;
   logic [6:0] addr = '0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_n;
   int checks = 0;
   int errors = 0;

   localparam logic [6:0] A_CTL = 7'h0B, A_ST = 7'h0C, A_VAL = 7'h0D;

   always #10 clk = ~clk;

   rtc_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .vrt_i(vrt), .addr_i(addr),
      .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [6:0] a, input logic [2:0] ev, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; evt = ev;
      #2 d = rdata;
      @(negedge clk); rd = 1'b0; evt = '0;
   endtask

   task automatic pulse(input logic [2:0] ev);
      @(negedge clk); evt = ev;
      @(negedge clk); evt = '0;
   endtask

   // status value expected from flags f and enables e (bit 2 periodic .. bit 0 update)
   function automatic logic [7:0] st_exp(input logic [2:0] f, input logic [2:0] e);
      return {|(f & e), f, 4'b0000};
   endfunction

   initial begin
      logic [7:0] d;
      #200000000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", {7'd0, irq_n}, 8'h01);
      rd_reg(A_ST, 3'b000, d);  check("R1 status", d, 8'h00);
      rd_reg(A_CTL, 3'b000, d); check("R1 enables", d, 8'h00);

      // R2 R3 R4 R5 R6 R9: every enable pattern against every flag pattern
      for (int e = 0; e < 8; e++) begin
         wr_reg(A_CTL, 8'hFF & ~8'h70 | 8'(e << 4));
         rd_reg(A_CTL, 3'b000, d);
         check("R2 enable readback", d, 8'(e << 4));
         for (int f = 0; f < 8; f++) begin
            if (f != 0) pulse(3'(f));
            #2 check("R5 irq level", {7'd0, irq_n}, {7'd0, ~|(3'(f) & 3'(e))});
            rd_reg(A_ST, 3'b000, d);
            check("R3 R4 R9 status", d, st_exp(3'(f), 3'(e)));
            #2 check("R6 irq after clear", {7'd0, irq_n}, 8'h01);
            rd_reg(A_ST, 3'b000, d);
            check("R6 cleared", d, st_exp(3'b000, 3'(e)));
         end
      end

      // R7 event during status read survives
      wr_reg(A_CTL, 8'h40);
      pulse(3'b010);
      rd_reg(A_ST, 3'b100, d);
      check("R7 read excludes new event", d, 8'h20);
      #2 check("R7 irq from new event", {7'd0, irq_n}, 8'h00);
      rd_reg(A_ST, 3'b000, d);
      check("R7 new event kept", d, 8'hC0);

      // R8 writes to status do nothing
      pulse(3'b001);
      wr_reg(A_ST, 8'hFF);
      wr_reg(A_ST, 8'h00);
      rd_reg(A_ST, 3'b000, d);
      check("R8 flag survives write", d, 8'h10);
      wr_reg(A_ST, 8'hF0);
      rd_reg(A_ST, 3'b000, d);
      check("R8 write sets nothing", d, 8'h00);

      // R11 other reads keep flags
      pulse(3'b110);
      rd_reg(A_CTL, 3'b000, d);
      rd_reg(A_VAL, 3'b000, d);
      rd_reg(7'h0E, 3'b000, d);
      rd_reg(A_ST, 3'b000, d);
      check("R11 flags kept", d, 8'hE0);

      // R10 validity register
      vrt = 1'b1;
      wr_reg(A_VAL, 8'h00);
      rd_reg(A_VAL, 3'b000, d); check("R10 valid set", d, 8'h80);
      vrt = 1'b0;
      wr_reg(A_VAL, 8'h7F);
      rd_reg(A_VAL, 3'b000, d); check("R10 valid clear", d, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule